// File: doc/BRIEF.md
# SDRAM Power-On Initialization Sequencer

This block owns the command pins of a single-rank SDRAM from reset until the memory is fit for normal traffic. Once reset is released it raises clock enable and holds the bus in the no-operation state for a long stabilization window. It then closes every bank with one precharge-all and runs a configurable number of auto-refresh cycles. Last, it loads the mode register with the word presented on its input and raises a ready flag after a short recovery gap.

All spacing is counted in clock cycles. Each gap is the rounded-up quotient of a nanosecond timing parameter and the clock period parameter, so one description serves any clock rate. The stabilization time is a parameter of its own, which lets a simulation shorten the wait. The controller that takes over the bus after start-up holds off until the ready flag is high. It reads the mode word only in the single cycle in which the mode register write goes out.

Top module: `sdram_boot_seq`

## Requirements
- R1: While `rst` is high the outputs show a no-operation command ({cs_n,ras_n,cas_n,we_n} = 0111), `cke` = 0, `addr` = 0, `ba` = 0 and `init_done` = 0.
- R2: Counting the first rising edge with `rst` low as cycle 1, cycles 1 through S carry no-operation with `cke` = 1, where S = ceil(T_STABLE_NS / CLK_NS).
- R3: In cycle S+1 a precharge-all is driven for one cycle: pins 0010 with `addr[10]` = 1, all other address bits 0 and `ba` = 0.
- R4: The first auto-refresh appears exactly RP cycles after the precharge, RP = ceil(T_RP_NS / CLK_NS), with no-operation in between.
- R5: REF_COUNT auto-refresh commands (pins 0001, `cke` = 1, `addr` = 0) are issued, each starting RC cycles after the previous one, RC = ceil(T_RC_NS / CLK_NS), with no-operation in between.
- R6: RC cycles after the last auto-refresh a mode register write is driven for one cycle: pins 0000, `ba` = 0, `addr` equal to `mode_word` with bits 7, 8, 10 and 11 forced to 0. CAS latency 2 is written as bits 6..4 = 010, latency 3 as 011.
- R7: `init_done` rises exactly MRD cycles after the mode register write and then stays high with no-operation on the pins until the next reset.
- R8: Gap lengths round up: at a 20 ns clock, 30 ns gives 2 cycles and 80 ns gives 4 cycles.
- R9: `mode_word` has no effect outside the cycle in which the mode register write is issued: `addr` is 0 on every no-operation and refresh cycle whatever `mode_word` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_word | input | ADDR_W | Operating mode to load into the mode register |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank select |
| init_done | output | 1 | Start-up sequence complete |

## Verification
The case hardest to reach from the ports is a `mode_word` that changes around the mode register write. The block must catch the value at exactly one edge and show none of it anywhere else. The stimulus drives the wanted word only in the half cycle before that edge and drives its complement in every other cycle, so a write that comes one cycle early or late, or an address that leaks the input, gives a miscompare. A reset forced in the middle of the stabilization window, followed by a complete second run, shows that the counters restart from scratch.

// File: rtl/sdram_boot_pkg.sv
`timescale 1ns/1ps
package sdram_boot_pkg;

   // Pin encoding {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_NOP = 4'b0111,
      CMD_PRE = 4'b0010,
      CMD_REF = 4'b0001,
      CMD_MRS = 4'b0000
   } sdram_cmd_e;

   typedef enum logic [2:0] {
      ST_STABLE,
      ST_PRE_GAP,
      ST_REF_GAP,
      ST_MRS_GAP,
      ST_READY
   } boot_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/boot_timer.sv
`timescale 1ns/1ps
module boot_timer #(
   parameter int CNT_W     = 16,
   parameter int RESET_VAL = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= CNT_W'(RESET_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/boot_refcnt.sv
`timescale 1ns/1ps
module boot_refcnt #(
   parameter int REF_COUNT = 8,
   localparam int RW = $clog2(REF_COUNT + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic inc,
   output logic all_done
);
   logic [RW-1:0] issued;

   always_ff @(posedge clk) begin
      if (rst)
         issued <= '0;
      else if (inc && !all_done)
         issued <= issued + 1'b1;
   end

   assign all_done = (issued == RW'(REF_COUNT));
endmodule

// File: rtl/boot_ctrl.sv
`timescale 1ns/1ps
module boot_ctrl
   import sdram_boot_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int RP_CYC  = 4,
   parameter int RC_CYC  = 10,
   parameter int MRD_CYC = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             gap_zero,
   input  logic             refs_done,
   output sdram_cmd_e       cmd_next,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             ref_inc,
   output logic             ready
);
   localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(RP_CYC - 1);
   localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(RC_CYC - 1);
   localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(MRD_CYC - 1);

   boot_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      cmd_next = CMD_NOP;
      load     = 1'b0;
      load_val = '0;
      ref_inc  = 1'b0;
      if (gap_zero) begin
         unique case (state)
            ST_STABLE: begin
               cmd_next = CMD_PRE;
               load     = 1'b1;
               load_val = LD_RP;
               state_nx = ST_PRE_GAP;
            end
            ST_PRE_GAP: begin
               cmd_next = CMD_REF;
               load     = 1'b1;
               load_val = LD_RC;
               ref_inc  = 1'b1;
               state_nx = ST_REF_GAP;
            end
            ST_REF_GAP: begin
               load = 1'b1;
               if (refs_done) begin
                  cmd_next = CMD_MRS;
                  load_val = LD_MRD;
                  state_nx = ST_MRS_GAP;
               end else begin
                  cmd_next = CMD_REF;
                  load_val = LD_RC;
                  ref_inc  = 1'b1;
               end
            end
            ST_MRS_GAP: state_nx = ST_READY;
            default:    state_nx = ST_READY;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_STABLE;
      else     state <= state_nx;
   end

   assign ready = (state == ST_READY);
endmodule

// File: rtl/boot_cmd_out.sv
`timescale 1ns/1ps
module boot_cmd_out
   import sdram_boot_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int BA_W   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  sdram_cmd_e        cmd_next,
   input  logic [ADDR_W-1:0] mode_word,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              cke,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba
);
   localparam int AP_BIT = 10;

   logic [ADDR_W-1:0] keep_mask;
   logic [ADDR_W-1:0] addr_nx;

   // Bits 7, 8, 10, 11 must be low during the mode load
   for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
      if (b == 7 || b == 8 || b == 10 || b == 11) begin : g_rsvd
         assign keep_mask[b] = 1'b0;
      end else begin : g_keep
         assign keep_mask[b] = 1'b1;
      end
   end

   always_comb begin
      unique case (cmd_next)
         CMD_PRE: addr_nx = ADDR_W'(1) << AP_BIT;
         CMD_MRS: addr_nx = mode_word & keep_mask;
         default: addr_nx = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
         cke  <= 1'b0;
         addr <= '0;
         ba   <= '0;
      end else begin
         {cs_n, ras_n, cas_n, we_n} <= cmd_next;
         cke  <= 1'b1;
         addr <= addr_nx;
         ba   <= '0;
      end
   end
endmodule

// File: rtl/sdram_boot_seq.sv
`timescale 1ns/1ps
module sdram_boot_seq
   import sdram_boot_pkg::*;
#(
   parameter int CLK_NS      = 8,
   parameter int T_STABLE_NS = 200000,
   parameter int T_RP_NS     = 30,
   parameter int T_RC_NS     = 80,
   parameter int REF_COUNT   = 8,
   parameter int MRD_CYC     = 2,
   parameter int ADDR_W      = 12,
   parameter int BA_W        = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] mode_word,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              cke,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              init_done
);
   localparam int STABLE_CYC = ceil_div(T_STABLE_NS, CLK_NS);
   localparam int RP_CYC     = ceil_div(T_RP_NS, CLK_NS);
   localparam int RC_CYC     = ceil_div(T_RC_NS, CLK_NS);
   localparam int MAX_WAIT   = (STABLE_CYC > RC_CYC) ? STABLE_CYC : RC_CYC;
   localparam int CNT_W      = $clog2(MAX_WAIT + 1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("CLK_NS must be positive");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must cover bit 11");
   end
   if (BA_W < 1) begin : g_bad_ba
      $error("BA_W must be at least 1");
   end
   if (REF_COUNT < 1) begin : g_bad_ref
      $error("REF_COUNT must be at least 1");
   end
   if (RP_CYC < 1 || RC_CYC < 1 || MRD_CYC < 1 || STABLE_CYC < 1) begin : g_bad_gap
      $error("every gap must span at least one cycle");
   end

   logic             gap_zero;
   logic             refs_done;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             ref_inc;
   sdram_cmd_e       cmd_next;

   boot_timer #(.CNT_W(CNT_W), .RESET_VAL(STABLE_CYC)) u_timer (
      .clk(clk), .rst(rst), .load(load), .load_val(load_val), .zero(gap_zero)
   );

   boot_refcnt #(.REF_COUNT(REF_COUNT)) u_refcnt (
      .clk(clk), .rst(rst), .inc(ref_inc), .all_done(refs_done)
   );

   boot_ctrl #(.CNT_W(CNT_W), .RP_CYC(RP_CYC), .RC_CYC(RC_CYC), .MRD_CYC(MRD_CYC)) u_ctrl (
      .clk(clk), .rst(rst), .gap_zero(gap_zero), .refs_done(refs_done),
      .cmd_next(cmd_next), .load(load), .load_val(load_val),
      .ref_inc(ref_inc), .ready(init_done)
   );

   boot_cmd_out #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_out (
      .clk(clk), .rst(rst), .cmd_next(cmd_next), .mode_word(mode_word),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .cke(cke), .addr(addr), .ba(ba)
   );
endmodule

// File: rtl/sdram_boot_chk.sv
`timescale 1ns/1ps
module sdram_boot_chk #(
   parameter int ADDR_W = 12,
   parameter int BA_W   = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic              cke,
   input logic [ADDR_W-1:0] addr,
   input logic [BA_W-1:0]   ba,
   input logic              init_done
);
   logic [3:0] pins;
   assign pins = {cs_n, ras_n, cas_n, we_n};

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);                                    // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      init_done |-> (pins == 4'b0111));                            // R7
   AST_PRE_ALLBANK: assert property (@(posedge clk) disable iff (rst)
      (pins == 4'b0010) |-> addr[10]);                             // R3
   AST_PRE_ONCE: assert property (@(posedge clk) disable iff (rst)
      (pins == 4'b0010) |=> (pins != 4'b0010));                    // R4
   AST_REF_CKE: assert property (@(posedge clk) disable iff (rst)
      (pins == 4'b0001) |-> (cke && addr == '0));                  // R5
   AST_MRS_RSVD: assert property (@(posedge clk) disable iff (rst)
      (pins == 4'b0000) |-> (!addr[7] && !addr[8] && !addr[10] && !addr[11] && ba == '0)); // R6
   AST_MRS_ONCE: assert property (@(posedge clk) disable iff (rst)
      (pins == 4'b0000) |=> (pins == 4'b0111));                    // R6
   AST_NOP_ADDR: assert property (@(posedge clk) disable iff (rst)
      (pins == 4'b0111) |-> (addr == '0));                         // R9
endmodule

bind sdram_boot_seq sdram_boot_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
   .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
   .we_n(we_n), .cke(cke), .addr(addr), .ba(ba), .init_done(init_done)
);

// File: tb/sdram_boot_seq_bench.sv
`timescale 1ns/1ps
module sdram_boot_seq_bench;
   // 20 ns clock: stabilization 1000 ns -> 50 cycles, 30 ns -> 2, 80 ns -> 4
   localparam int S     = 50;
   localparam int RP    = 2;
   localparam int RC    = 4;
   localparam int NREF  = 8;
   localparam int MRD   = 2;
   localparam int P_CYC = S + 1;
   localparam int R0    = P_CYC + RP;
   localparam int M_CYC = R0 + NREF * RC;
   localparam int D_CYC = M_CYC + MRD;

   // {mode_word, expected address in the mode-load cycle}
   localparam logic [23:0] VEC [4] = '{
      {12'h032, 12'h032},   // latency 3, sequential, length 4
      {12'h023, 12'h023},   // latency 2, length 8
      {12'hFFF, 12'h27F},   // all ones: bits 7, 8, 10, 11 cleared
      {12'h000, 12'h000}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] mode_word = '0;
   logic        cs_n, ras_n, cas_n, we_n, cke, init_done;
   logic [11:0] addr;
   logic [1:0]  ba;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   sdram_boot_seq #(
      .CLK_NS(20), .T_STABLE_NS(1000), .T_RP_NS(30), .T_RC_NS(80),
      .REF_COUNT(NREF), .MRD_CYC(MRD), .ADDR_W(12), .BA_W(2)
   ) u_sdram_boot_seq (
      .clk(clk), .rst(rst), .mode_word(mode_word),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .cke(cke), .addr(addr), .ba(ba), .init_done(init_done)
   );

   // {pins[3:0], cke, done, ba[1:0], addr[11:0]}
   function automatic logic [19:0] expect_at(input int k, input logic [11:0] mexp);
      logic is_ref;
      is_ref = (k >= R0) && (k < M_CYC) && ((k - R0) % RC == 0);
      if (k == P_CYC)      return {4'b0010, 1'b1, 1'b0, 2'b00, 12'h400};
      else if (is_ref)     return {4'b0001, 1'b1, 1'b0, 2'b00, 12'h000};
      else if (k == M_CYC) return {4'b0000, 1'b1, 1'b0, 2'b00, mexp};
      else                 return {4'b0111, 1'b1, (k >= D_CYC), 2'b00, 12'h000};
   endfunction

   function automatic string tag_at(input int k);
      if (k <= S)          return "R2";
      else if (k == P_CYC) return "R3/R8";
      else if (k == R0)    return "R4/R8";
      else if (k < M_CYC)  return "R5/R9";
      else if (k == M_CYC) return "R6";
      else                 return "R7";
   endfunction

   task automatic compare(input logic [19:0] exp, input string tag, input int k);
      logic [19:0] act;
      act = {cs_n, ras_n, cas_n, we_n, cke, init_done, ba, addr};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %h expected %h", tag, k, act, exp);
      end
   endtask

   task automatic check_reset(input int cycles);
      rst = 1'b1;
      for (int i = 0; i < cycles; i++) begin
         @(posedge clk);
         @(negedge clk);
         mode_word = 12'hFFF;
         compare({4'b0111, 1'b0, 1'b0, 2'b00, 12'h000}, "R1", -1);
      end
   endtask

   // Runs cycles 1..last after releasing reset; mode_word valid only for the load edge
   task automatic run_seq(input logic [11:0] mw, input logic [11:0] mexp, input int last);
      @(negedge clk);
      rst = 1'b0;
      mode_word = (M_CYC == 1) ? mw : ~mw;
      for (int k = 1; k <= last; k++) begin
         @(posedge clk);
         @(negedge clk);
         mode_word = (k + 1 == M_CYC) ? mw : ~mw;
         compare(expect_at(k, mexp), tag_at(k), k);
      end
   endtask

   initial begin : watchdog
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      check_reset(3);                                   // R1
      for (int v = 0; v < 4; v++) begin
         run_seq(VEC[v][23:12], VEC[v][11:0], D_CYC + 4);
         check_reset(2);                                // R1 after a full run
      end
      // Reset in the middle of the stabilization window, then a clean rerun
      run_seq(12'h032, 12'h032, 30);
      check_reset(2);                                   // R1
      run_seq(12'h032, 12'h032, D_CYC + 6);             // R2..R9 from scratch
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule